// File: doc/BRIEF.md
# Multiprocessor-aware asynchronous serial receiver

This block turns an asynchronous serial line into parallel characters. A baud strobe that pulses sixteen times per bit period paces it. The frame shape is set by configuration inputs: 5 to 9 data bits, no parity or even or odd parity, and one or two stop bits. The configuration is captured when a start bit is detected, so a change in the middle of a frame does not affect the character being received. Each bit is decided by a three-sample majority vote taken around the middle of the bit. A start edge that does not hold until mid-bit is discarded as noise.

Finished characters enter a two-deep receive queue. Each entry stores the nine data bits together with a framing flag and a parity flag. The head entry is always visible on the read outputs: the ninth bit, the low byte and that entry's two flags. A one-cycle read strobe pops the head. A sticky overrun flag reports a character that was lost because the queue was full.

In multiprocessor mode, frames whose ninth bit is 1 are address frames. Frames whose ninth bit is 0 are data frames. Address frames are always queued, and each one closes an acceptance window. While the window is closed, data frames are dropped. Host logic opens the window with a single-cycle accept pulse once it has decided that the address matched.

Top module: `mp_uart_rx`

## Requirements
- R1: The size code `cfg_size` selects the number of data bits as the code plus 5 (0 gives 5 bits, 4 gives 9 bits). Codes above 4 also select 9 bits. Data arrives least significant bit first. Data bits beyond the configured count read as 0 in `{rd_bit8, rd_byte}`.
- R2: Each bit value is the majority of three line samples taken on consecutive baud strobes near mid-bit. A disturbance that covers only one of those samples does not change the received bit.
- R3: A falling edge on the line starts a frame only if the voted start-bit value is still low at mid-bit. Otherwise the receiver returns to idle and stores nothing.
- R4: If any configured stop bit (one, or both when `cfg_stop2`=1) is voted low, the character is still queued and its `rd_fe` reads 1. Otherwise `rd_fe` reads 0.
- R5: With `cfg_par_en`=1, the expected parity bit is the XOR of the data bits, inverted when `cfg_par_odd`=1. A received parity bit that differs from it sets `rd_pe` for that character. With `cfg_par_en`=0, no parity bit is expected and `rd_pe` reads 0.
- R6: The queue holds two characters in arrival order. `rx_avail` is 1 whenever at least one entry is held.
- R7: The head entry (`rd_bit8`, `rd_byte`, `rd_fe`, `rd_pe`) stays unchanged, and can be read any number of times, until `rd_en` is pulsed. Each `rd_en` cycle removes exactly one entry. `rd_en` on an empty queue has no effect.
- R8: A character that completes while two entries are held, with no `rd_en` in the same cycle, is discarded and sets `rx_ovr`. `rx_ovr` clears on the next `rd_en` that removes an entry.
- R9: With `cfg_mp_en`=1, a frame whose ninth bit is 1 is always queued and closes the acceptance window. A pulse on `mp_accept` opens the window. A frame whose ninth bit is 0 is queued only while the window is open. Dropped frames change neither the queue nor `rx_ovr`.
- R10: After a synchronous reset, the queue is empty, `rx_avail` and `rx_ovr` are 0, and the acceptance window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_size | input | 3 | Data bit count minus 5 (values above 4 select 9) |
| cfg_par_en | input | 1 | 1 expects a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 expects two stop bits |
| cfg_mp_en | input | 1 | 1 enables address/data filtering on the ninth bit |
| mp_accept | input | 1 | Pulse that opens the data acceptance window |
| rd_en | input | 1 | Pops the head entry |
| rd_bit8 | output | 1 | Ninth data bit of the head entry |
| rd_byte | output | 8 | Low eight data bits of the head entry |
| rd_fe | output | 1 | Framing error of the head entry |
| rd_pe | output | 1 | Parity error of the head entry |
| rx_avail | output | 1 | At least one character is queued |
| rx_ovr | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following on every cycle:
- the head entry does not move without a read;
- a read on an empty queue leaves it empty;
- a push always produces a visible entry;
- an overflowing push raises the overrun flag;
- a data frame that arrives while the window is closed never reaches the queue;
- reset empties the queue and clears the overrun flag.

Bit-level behaviour can only be shown by the bench, because it depends on the stimulus: majority voting against a one-sample glitch, rejection of a short start pulse, the decoding of each frame size, parity computed over a variable number of bits, and a framing error on the second stop bit. The bench drives whole frames for these cases and compares the resulting head entries.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int DATA_W = 9;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fe;
    logic              pe;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/mpr_sampler.sv
module mpr_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  output logic line,
  output logic vote
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             win_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  assign line = sync_q[SYNC_STAGES-1];

  // three most recent strobe-aligned samples
  always_ff @(posedge clk) begin
    if (rst)       win_q <= 3'b111;
    else if (tick) win_q <= {win_q[1:0], line};
  end

  assign vote = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
  import mpr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     line,
  input  logic     vote,
  input  logic [2:0] cfg_size,
  input  logic     cfg_par_en,
  input  logic     cfg_par_odd,
  input  logic     cfg_stop2,
  output logic     done,
  output rx_char_t char_out
);
  localparam int PH_W  = $clog2(OVS);
  localparam int CNT_W = $clog2(DATA_W + 8);
  // samples at phases CHK-3..CHK-1 are in the vote window when phase==CHK
  localparam logic [PH_W-1:0] CHK  = PH_W'(OVS / 2 + 2);
  localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

  rx_state_t         state_q;
  logic [PH_W-1:0]   phase_q;
  logic [CNT_W-1:0]  bitn_q, nbits_q, nb_dec;
  logic              par_en_q, odd_q, stop2_q, stop_idx_q, fe_acc_q, pe_q;
  logic [DATA_W-1:0] shreg_q;

  always_comb begin
    nb_dec = CNT_W'(cfg_size) + CNT_W'(5);
    if (nb_dec > CNT_W'(DATA_W)) nb_dec = CNT_W'(DATA_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      phase_q    <= '0;
      bitn_q     <= '0;
      nbits_q    <= CNT_W'(DATA_W);
      par_en_q   <= 1'b0;
      odd_q      <= 1'b0;
      stop2_q    <= 1'b0;
      stop_idx_q <= 1'b0;
      fe_acc_q   <= 1'b0;
      pe_q       <= 1'b0;
      shreg_q    <= '0;
      done       <= 1'b0;
      char_out   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state_q)
          ST_IDLE: begin
            if (!line) begin
              state_q    <= ST_START;
              phase_q    <= '0;
              bitn_q     <= '0;
              nbits_q    <= nb_dec;
              par_en_q   <= cfg_par_en;
              odd_q      <= cfg_par_odd;
              stop2_q    <= cfg_stop2;
              stop_idx_q <= 1'b0;
              fe_acc_q   <= 1'b0;
              pe_q       <= 1'b0;
              shreg_q    <= '0;
            end
          end
          ST_START: begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == CHK && vote) begin
              state_q <= ST_IDLE;
            end else if (phase_q == LAST) begin
              phase_q <= '0;
              state_q <= ST_DATA;
            end
          end
          ST_DATA: begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == CHK) shreg_q[bitn_q] <= vote;
            if (phase_q == LAST) begin
              phase_q <= '0;
              bitn_q  <= bitn_q + 1'b1;
              if (bitn_q == nbits_q - 1'b1)
                state_q <= par_en_q ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == CHK) pe_q <= vote ^ (^shreg_q) ^ odd_q;
            if (phase_q == LAST) begin
              phase_q <= '0;
              state_q <= ST_STOP;
            end
          end
          ST_STOP: begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == CHK) begin
              if (stop2_q && !stop_idx_q) begin
                fe_acc_q <= fe_acc_q | ~vote;
              end else begin
                done          <= 1'b1;
                char_out.data <= shreg_q;
                char_out.fe   <= fe_acc_q | ~vote;
                char_out.pe   <= pe_q;
                state_q       <= ST_IDLE;
              end
            end else if (phase_q == LAST) begin
              phase_q    <= '0;
              stop_idx_q <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpr_mpfilter.sv
module mpr_mpfilter
  import mpr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  rx_char_t in_char,
  input  logic     mp_en,
  input  logic     accept,
  output logic     push,
  output rx_char_t push_char,
  output logic     win_open
);
  logic is_addr;
  assign is_addr = in_char.data[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      push      <= 1'b0;
      push_char <= '0;
      win_open  <= 1'b0;
    end else begin
      push      <= 1'b0;
      push_char <= in_char;
      if (accept) win_open <= 1'b1;
      if (in_valid) begin
        if (!mp_en) begin
          push <= 1'b1;
        end else if (is_addr) begin
          push     <= 1'b1;
          win_open <= 1'b0;
        end else if (win_open) begin
          push <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mpr_rxbuf.sv
module mpr_rxbuf
  import mpr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  rx_char_t push_char,
  input  logic     pop,
  output rx_char_t head,
  output logic     avail,
  output logic     full,
  output logic     ovr
);
  rx_char_t   tail_q;
  logic [1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      tail_q <= '0;
      cnt_q  <= 2'd0;
      ovr    <= 1'b0;
    end else begin
      if (pop && cnt_q != 2'd0) ovr <= 1'b0;
      case (cnt_q)
        2'd0: begin
          if (push) begin
            head  <= push_char;
            cnt_q <= 2'd1;
          end
        end
        2'd1: begin
          if (push && pop) begin
            head <= push_char;
          end else if (push) begin
            tail_q <= push_char;
            cnt_q  <= 2'd2;
          end else if (pop) begin
            cnt_q <= 2'd0;
          end
        end
        default: begin
          if (pop) begin
            head <= tail_q;
            if (push) tail_q <= push_char;
            else      cnt_q  <= 2'd1;
          end else if (push) begin
            ovr <= 1'b1;
          end
        end
      endcase
    end
  end

  assign avail = cnt_q != 2'd0;
  assign full  = cnt_q == 2'd2;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpr_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic [2:0] cfg_size,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_mp_en,
  input  logic       mp_accept,
  input  logic       rd_en,
  output logic       rd_bit8,
  output logic [7:0] rd_byte,
  output logic       rd_fe,
  output logic       rd_pe,
  output logic       rx_avail,
  output logic       rx_ovr
);
  logic     line_w, vote_w, frm_done, push_w, full_w, mp_open_w;
  rx_char_t frm_char, push_char, head_w;

  mpr_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd),
    .line(line_w), .vote(vote_w)
  );

  mpr_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst(rst), .tick(baud_tick), .line(line_w), .vote(vote_w),
    .cfg_size(cfg_size), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .done(frm_done), .char_out(frm_char)
  );

  mpr_mpfilter u_filt (
    .clk(clk), .rst(rst), .in_valid(frm_done), .in_char(frm_char),
    .mp_en(cfg_mp_en), .accept(mp_accept), .push(push_w),
    .push_char(push_char), .win_open(mp_open_w)
  );

  mpr_rxbuf u_buf (
    .clk(clk), .rst(rst), .push(push_w), .push_char(push_char), .pop(rd_en),
    .head(head_w), .avail(rx_avail), .full(full_w), .ovr(rx_ovr)
  );

  assign rd_bit8 = head_w.data[DATA_W-1];
  assign rd_byte = head_w.data[7:0];
  assign rd_fe   = head_w.fe;
  assign rd_pe   = head_w.pe;
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic       rx_avail,
  input logic       rx_ovr,
  input logic       rd_bit8,
  input logic [7:0] rd_byte,
  input logic       rd_fe,
  input logic       rd_pe,
  input logic       push,
  input logic       full,
  input logic       frm_done,
  input logic       frm_bit8,
  input logic       mp_en,
  input logic       mp_open
);
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (!rx_avail && !rx_ovr)); // R10

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_avail && !rd_en) |=> ($stable(rd_byte) && $stable(rd_bit8) && $stable(rd_fe) && $stable(rd_pe))); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (!rx_avail && rd_en && !push) |=> !rx_avail); // R7

  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (push && !rd_en) |=> rx_avail); // R6

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (push && full && !rd_en) |=> rx_ovr); // R8

  AST_MP_DROP: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_en && !frm_bit8 && !mp_open) |=> !push); // R9
endmodule

bind mp_uart_rx mpr_checker u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rx_avail(rx_avail), .rx_ovr(rx_ovr),
  .rd_bit8(rd_bit8), .rd_byte(rd_byte), .rd_fe(rd_fe), .rd_pe(rd_pe),
  .push(push_w), .full(full_w), .frm_done(frm_done), .frm_bit8(frm_char.data[8]),
  .mp_en(cfg_mp_en), .mp_open(mp_open_w)
);

// File: tb/mp_uart_rx_tb.sv
`timescale 1ns/1ps
module mp_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [2:0] cfg_size = 3'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       cfg_mp_en = 1'b0, mp_accept = 1'b0, rd_en = 1'b0;
  logic       rd_bit8, rd_fe, rd_pe, rx_avail, rx_ovr;
  logic [7:0] rd_byte;
  int         checks = 0, errors = 0, tdiv = 0;

  localparam int CLK_PER_TICK = 4;
  localparam int CLK_PER_BIT  = 16 * CLK_PER_TICK;

  // {size[2:0], par_en, par_odd, stop2, bad_par, bad_stop, data[8:0], exp_data[8:0], exp_fe, exp_pe}
  localparam logic [27:0] VEC [8] = '{
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1F3, 9'h013, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h02C, 9'h02C, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h055, 9'h055, 1'b0, 1'b1},
    {3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h1C3, 9'h1C3, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h03C, 9'h03C, 1'b1, 1'b0},
    {3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h100, 9'h100, 1'b1, 1'b0},
    {3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 9'h000, 9'h000, 1'b1, 1'b1}
  };

  mp_uart_rx u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_size(cfg_size), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_mp_en(cfg_mp_en), .mp_accept(mp_accept),
    .rd_en(rd_en), .rd_bit8(rd_bit8), .rd_byte(rd_byte), .rd_fe(rd_fe),
    .rd_pe(rd_pe), .rx_avail(rx_avail), .rx_ovr(rx_ovr)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == CLK_PER_TICK - 1) begin
      tdiv = 0;
      baud_tick = 1'b1;
    end else begin
      tdiv = tdiv + 1;
      baud_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (CLK_PER_BIT) @(negedge clk);
  endtask

  task automatic send_frame(input int nb, input logic [8:0] d, input logic pen,
                            input logic podd, input logic st2, input logic bpar,
                            input logic bstop, input int glitch_bit);
    logic p;
    p = podd ^ bpar;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      p = p ^ d[i];
      if (i == glitch_bit) begin
        rxd = d[i];
        repeat (CLK_PER_BIT / 2) @(negedge clk);
        rxd = ~d[i];
        repeat (CLK_PER_TICK) @(negedge clk);
        rxd = d[i];
        repeat (CLK_PER_BIT / 2 - CLK_PER_TICK) @(negedge clk);
      end else begin
        send_bit(d[i]);
      end
    end
    if (pen) send_bit(p);
    if (st2) send_bit(1'b1);
    send_bit(~bstop);
    rxd = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2:0] sz, input logic pen, input logic podd,
                         input logic st2, input logic mp);
    cfg_size = sz; cfg_par_en = pen; cfg_par_odd = podd;
    cfg_stop2 = st2; cfg_mp_en = mp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 avail", rx_avail, 0);
    check("R10 ovr", rx_ovr, 0);

    // table walk: R1 sizes, R4 framing, R5 parity, R6 avail
    for (int v = 0; v < 8; v++) begin
      int nb;
      logic [27:0] e;
      e  = VEC[v];
      nb = (e[27:25] > 3'd4) ? 9 : int'(e[27:25]) + 5;
      set_cfg(e[27:25], e[24], e[23], e[22], 1'b0);
      send_frame(nb, e[19:11], e[24], e[23], e[22], e[21], e[20], -1);
      check("R6 avail after frame", rx_avail, 1);
      check("R1 data", {rd_bit8, rd_byte}, e[10:2]);
      check("R4 framing flag", rd_fe, e[1]);
      check("R5 parity flag", rd_pe, e[0]);
      pop();
      check("R7 pop empties", rx_avail, 0);
    end

    // R7: rd_en on empty queue ignored, head held without reads
    set_cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    pop();
    check("R7 empty pop", rx_avail, 0);
    send_frame(8, 9'h0C6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    repeat (300) @(negedge clk);
    check("R7 head held", {rx_avail, rd_bit8, rd_byte}, {1'b1, 9'h0C6});
    pop();

    // R2: one-sample glitch in the middle of bit 3
    send_frame(8, 9'h05A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    check("R2 glitch voted out", {rd_bit8, rd_byte}, 9'h05A);
    pop();

    // R3: short low pulse is not a start bit
    rxd = 1'b0;
    repeat (3 * CLK_PER_TICK) @(negedge clk);
    rxd = 1'b1;
    repeat (20 * CLK_PER_BIT) @(negedge clk);
    check("R3 false start", rx_avail, 0);

    // R8 overrun and R6 ordering
    send_frame(8, 9'h011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    send_frame(8, 9'h022, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check("R8 no overrun at two", rx_ovr, 0);
    send_frame(8, 9'h033, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check("R8 overrun set", rx_ovr, 1);
    check("R6 order first", rd_byte, 8'h11);
    pop();
    check("R8 overrun cleared by read", rx_ovr, 0);
    check("R6 order second", rd_byte, 8'h22);
    pop();
    check("R8 lost char absent", rx_avail, 0);

    // R9 multiprocessor filtering
    set_cfg(3'd4, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(9, 9'h045, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check("R9 data dropped while closed", rx_avail, 0);
    send_frame(9, 9'h1A0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check("R9 address kept", {rx_avail, rd_bit8, rd_byte}, {1'b1, 9'h1A0});
    pop();
    mp_accept = 1'b1;
    @(negedge clk);
    mp_accept = 1'b0;
    send_frame(9, 9'h033, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check("R9 data kept while open", {rx_avail, rd_bit8, rd_byte}, {1'b1, 9'h033});
    pop();
    send_frame(9, 9'h1B1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    pop();
    send_frame(9, 9'h077, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check("R9 new address closes window", rx_avail, 0);
    check("R9 drop leaves overrun clear", rx_ovr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule